// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Master

This block is a 2-wire bus master. It waits until a serial memory has finished its internal write cycle. The caller first closes the preceding byte or page load with a stop condition, then pulses `go_i` with the 7-bit device address and the direction of the command that will follow. The block sends a start condition and the address byte, then listens on the ninth clock. A missing acknowledge is not a bus error. It means the memory is still busy, so the block sends a stop and tries again.

The first acknowledge ends the wait. The block then raises `done_o` and does not send a stop. It parks the bus with SCL held low and SDA released, so the next read or write sequence can carry on from the acknowledged address byte. A programmable attempt limit guards the loop. When the limit runs out, `timeout_o` rises and the bus is released with a stop. `tries_o` reports how many address bytes were sent.

SCL and SDA are open-drain: an `_oe_o` output at 1 pulls the line low. A parameterised divider sets the bus step. No arbitration or clock stretching is performed.

Top module: `ackpoll_master`

## Requirements
- R1: After reset, SCL and SDA are released (both `_oe_o` low), and `busy_o`, `done_o` and `timeout_o` are low. `tries_o` is 0.
- R2: Each attempt is one start condition followed by the byte `{dev_addr_i, rw_i}` sent MSB first, with bit 0 as the direction flag (1 = read). SDA is then released for the ninth clock.
- R3: A high SDA on the ninth clock counts as busy. The block sends a stop and then a new attempt with the same byte, and raises no timeout before the limit is reached.
- R4: A low SDA on the ninth clock sets `done_o`. No stop follows. SCL stays held low and SDA released. `tries_o` equals the number of address bytes sent.
- R5: With limit L on `max_tries_i` (0 is treated as 1), L unanswered attempts end in a stop, `timeout_o` high, `done_o` low, `tries_o` = L and both lines released.
- R6: SDA changes only while SCL is held low, except for the SDA edge that forms a start or a stop.
- R7: A quarter bus period is QTR = CLK_HZ/(4*SCL_HZ) clocks, and every bus step (start, data bit, ninth bit, stop) takes 4*QTR+1 clocks. A run of n steps keeps `busy_o` high for n*(4*QTR+1) clocks after the clock edge that accepts `go_i`.
- R8: `go_i`, `rw_i`, `dev_addr_i` and `max_tries_i` are ignored while `busy_o` is high.
- R9: `done_o`, `timeout_o` and `tries_o` hold their values until the next accepted `go_i`, which clears them. `done_o` and `timeout_o` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start a polling run (taken only when idle) |
| rw_i | input | 1 | Direction flag placed in the address byte LSB, 1 = read |
| dev_addr_i | input | 7 | 7-bit device address |
| max_tries_i | input | TRY_W | Attempt limit, 0 treated as 1 |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Polling run in progress |
| done_o | output | 1 | Memory acknowledged, bus parked |
| timeout_o | output | 1 | Limit reached without acknowledge |
| tries_o | output | TRY_W | Address bytes sent in the last run |

## Verification
Every result in this block is due at a cycle that can be counted in advance. A run of n bus steps ends exactly n*(4*QTR+1) clocks after the edge that accepts `go_i`: ten steps for a successful attempt and eleven for each unanswered one. The bench drives `go_i` at a falling edge and counts the falling-edge samples of `busy_o` against that figure. It reads `done_o`, `timeout_o`, `tries_o` and the line levels only after `busy_o` has dropped, and bus-level facts such as the address byte and the number of starts and stops are taken from a slave model that watches the line edges.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

    localparam int unsigned DEV_W = 7;

    typedef enum logic [1:0] {
        BUS_START = 2'd0,
        BUS_BIT   = 2'd1,
        BUS_STOP  = 2'd2
    } bus_cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_START = 3'd1,
        SQ_ADDR  = 3'd2,
        SQ_ACK   = 3'd3,
        SQ_STOP  = 3'd4
    } seq_state_e;

    // Line drive per quarter phase: {scl_oe, sda_oe}, 1 = pull low.
    function automatic logic [1:0] bus_drive(
        input bus_cmd_e   cmd,
        input logic       bit_v,
        input logic [1:0] phase,
        input logic       scl_now
    );
        logic [1:0] r;
        r = 2'b00;
        case (cmd)
            BUS_START: begin
                case (phase)
                    2'd0:    r = {scl_now, 1'b0};
                    2'd1:    r = 2'b00;
                    2'd2:    r = 2'b01;
                    default: r = 2'b11;
                endcase
            end
            BUS_STOP: begin
                case (phase)
                    2'd0:    r = 2'b11;
                    2'd1:    r = 2'b01;
                    default: r = 2'b00;
                endcase
            end
            default: begin
                r[0] = ~bit_v;
                r[1] = (phase == 2'd0) || (phase == 2'd3);
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ackpoll_qtick.sv
module ackpoll_qtick #(
    parameter int unsigned QTR = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = (QTR > 1) ? $clog2(QTR) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } qt_state_t;

    qt_state_t st_d, st_q;

    assign tick_o = en_i && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (!en_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: quarter counter never passes its last value
    a_r7_qtr_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

endmodule

// File: rtl/ackpoll_bitphy.sv
module ackpoll_bitphy
    import ackpoll_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_valid_i,
    input  bus_cmd_e cmd_i,
    input  logic     bit_i,
    input  logic     sda_i,
    input  logic     tick_i,
    output logic     run_o,
    output logic     done_o,
    output logic     rx_o,
    output logic     scl_oe_o,
    output logic     sda_oe_o
);
    typedef struct packed {
        logic       active;
        bus_cmd_e   cmd;
        logic       bitv;
        logic [1:0] phase;
        logic       rx;
        logic       scl_oe;
        logic       sda_oe;
    } phy_state_t;

    phy_state_t st_d, st_q;
    logic [1:0] drv;
    logic [1:0] phase_nx;

    assign phase_nx = st_q.phase + 2'd1;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        drv    = {st_q.scl_oe, st_q.sda_oe};
        if (!st_q.active) begin
            if (cmd_valid_i) begin
                st_d.active = 1'b1;
                st_d.cmd    = cmd_i;
                st_d.bitv   = bit_i;
                st_d.phase  = 2'd0;
                drv         = bus_drive(cmd_i, bit_i, 2'd0, st_q.scl_oe);
            end
        end else if (tick_i) begin
            if ((st_q.phase == 2'd1) && (st_q.cmd == BUS_BIT)) begin
                st_d.rx = sda_i;
            end
            if (st_q.phase == 2'd3) begin
                st_d.active = 1'b0;
                done_o      = 1'b1;
            end else begin
                st_d.phase = phase_nx;
                drv        = bus_drive(st_q.cmd, st_q.bitv, phase_nx, st_q.scl_oe);
            end
        end
        st_d.scl_oe = drv[1];
        st_d.sda_oe = drv[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, cmd: BUS_STOP, bitv: 1'b1, phase: 2'd0,
                      rx: 1'b1, scl_oe: 1'b0, sda_oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o    = st_q.active;
    assign rx_o     = st_q.rx;
    assign scl_oe_o = st_q.scl_oe;
    assign sda_oe_o = st_q.sda_oe;

    // R6: an SDA edge during a data bit happens with SCL held low on both sides
    a_r6_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.sda_oe != $past(st_q.sda_oe)) && (st_q.cmd == BUS_BIT))
            |-> (st_q.scl_oe && $past(st_q.scl_oe)));

    // R6: SDA and SCL never switch on the same edge
    a_r6_no_joint_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sda_oe != $past(st_q.sda_oe)) |-> (st_q.scl_oe == $past(st_q.scl_oe)));

endmodule

// File: rtl/ackpoll_master.sv
module ackpoll_master
    import ackpoll_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000_000,
    parameter int unsigned SCL_HZ = 400_000,
    parameter int unsigned TRY_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             rw_i,
    input  logic [DEV_W-1:0] dev_addr_i,
    input  logic [TRY_W-1:0] max_tries_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o,
    output logic [TRY_W-1:0] tries_o
);
    localparam int unsigned QTR_RAW = CLK_HZ / (4 * SCL_HZ);
    localparam int unsigned QTR     = (QTR_RAW > 0) ? QTR_RAW : 1;

    typedef struct packed {
        seq_state_e       state;
        logic [7:0]       addr_byte;
        logic [2:0]       bit_idx;
        logic             waiting;
        logic [TRY_W-1:0] tries;
        logic [TRY_W-1:0] limit;
        logic             done;
        logic             timeout;
    } seq_t;

    seq_t st_d, st_q;

    logic     cmd_valid;
    bus_cmd_e cmd;
    logic     cmd_bit;
    logic     phy_run;
    logic     phy_done;
    logic     phy_rx;
    logic     tick;

    ackpoll_qtick #(.QTR(QTR)) u_qtick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (phy_run),
        .tick_o (tick)
    );

    ackpoll_bitphy u_phy (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_i       (cmd),
        .bit_i       (cmd_bit),
        .sda_i       (sda_i),
        .tick_i      (tick),
        .run_o       (phy_run),
        .done_o      (phy_done),
        .rx_o        (phy_rx),
        .scl_oe_o    (scl_oe_o),
        .sda_oe_o    (sda_oe_o)
    );

    always_comb begin
        st_d    = st_q;
        cmd     = BUS_BIT;
        cmd_bit = 1'b1;

        case (st_q.state)
            SQ_START: cmd = BUS_START;
            SQ_ADDR:  cmd_bit = st_q.addr_byte[st_q.bit_idx];
            SQ_STOP:  cmd = BUS_STOP;
            default:  cmd = BUS_BIT;
        endcase

        cmd_valid = (st_q.state != SQ_IDLE) && !st_q.waiting;
        if (cmd_valid) begin
            st_d.waiting = 1'b1;
        end

        if (st_q.state == SQ_IDLE) begin
            if (go_i) begin
                st_d.state     = SQ_START;
                st_d.addr_byte = {dev_addr_i, rw_i};
                st_d.tries     = '0;
                st_d.limit     = (max_tries_i == '0) ? TRY_W'(1) : max_tries_i;
                st_d.done      = 1'b0;
                st_d.timeout   = 1'b0;
                st_d.waiting   = 1'b0;
            end
        end else if (phy_done) begin
            st_d.waiting = 1'b0;
            case (st_q.state)
                SQ_START: begin
                    st_d.state   = SQ_ADDR;
                    st_d.bit_idx = 3'd7;
                end
                SQ_ADDR: begin
                    if (st_q.bit_idx == 3'd0) begin
                        st_d.state = SQ_ACK;
                    end else begin
                        st_d.bit_idx = st_q.bit_idx - 3'd1;
                    end
                end
                SQ_ACK: begin
                    st_d.tries = st_q.tries + TRY_W'(1);
                    if (!phy_rx) begin
                        st_d.state = SQ_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.state = SQ_STOP;
                    end
                end
                SQ_STOP: begin
                    if (st_q.tries >= st_q.limit) begin
                        st_d.state   = SQ_IDLE;
                        st_d.timeout = 1'b1;
                    end else begin
                        st_d.state = SQ_START;
                    end
                end
                default: st_d.state = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: SQ_IDLE, addr_byte: 8'h00, bit_idx: 3'd7,
                      waiting: 1'b0, tries: '0, limit: TRY_W'(1),
                      done: 1'b0, timeout: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = (st_q.state != SQ_IDLE);
    assign done_o    = st_q.done;
    assign timeout_o = st_q.timeout;
    assign tries_o   = st_q.tries;

    // R9: the two end flags are exclusive
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.done && st_q.timeout));

    // R8: the latched byte stays put through a run
    a_r8_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(st_q.addr_byte));

    // R5: attempts never exceed the limit
    a_r5_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.tries <= st_q.limit));

    // R4: completion follows the ninth-bit step only
    a_r4_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> ($past(st_q.state) == SQ_ACK));

    // R7: a step is only launched while the bit engine is idle
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !phy_run);

endmodule

// File: tb/ackpoll_master_bench.sv
module ackpoll_master_bench;
    localparam int unsigned CLK_HZ = 100_000_000;
    localparam int unsigned SCL_HZ = 400_000;
    localparam int unsigned TRY_W  = 8;
    localparam int QTR  = CLK_HZ / (4 * SCL_HZ);
    localparam int STEP = 4 * QTR + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic rw = 1'b0;
    logic [6:0] dev = 7'h00;
    logic [TRY_W-1:0] max_tries = '0;
    logic scl_oe, sda_oe, busy, done, timeout;
    logic [TRY_W-1:0] tries;

    logic slave_pull = 1'b0;
    logic scl_bus, sda_bus;
    assign scl_bus = !scl_oe;
    assign sda_bus = !(sda_oe || slave_pull);

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    ackpoll_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .TRY_W(TRY_W)) u_ackpoll_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .rw_i        (rw),
        .dev_addr_i  (dev),
        .max_tries_i (max_tries),
        .sda_i       (sda_bus),
        .scl_oe_o    (scl_oe),
        .sda_oe_o    (sda_oe),
        .busy_o      (busy),
        .done_o      (done),
        .timeout_o   (timeout),
        .tries_o     (tries)
    );

    // Slave model: withholds the acknowledge for nack_n polls
    int nack_n = 0;
    int polls = 0, starts = 0, stops = 0, bitc = 0;
    logic in_frame = 1'b0;
    logic [7:0] shreg = 8'h00, first_byte = 8'h00;
    logic mismatch = 1'b0;

    always @(negedge sda_bus) if (scl_bus === 1'b1) begin
        starts++; in_frame = 1'b1; bitc = 0;
    end
    always @(posedge sda_bus) if (scl_bus === 1'b1) begin
        stops++; in_frame = 1'b0;
    end
    always @(posedge scl_bus) if (in_frame && bitc < 8) begin
        shreg = {shreg[6:0], sda_bus}; bitc++;
    end
    always @(negedge scl_bus) if (in_frame) begin
        if (bitc == 8) begin
            polls++;
            if (polls == 1) first_byte = shreg;
            else if (shreg != first_byte) mismatch = 1'b1;
            if (polls > nack_n) slave_pull = 1'b1;
            bitc = 9;
        end else if (bitc == 9) begin
            slave_pull = 1'b0; in_frame = 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one poll; optional stray go at cycle poke with another address.
    task automatic run_poll(input logic [6:0] d, input logic r, input int lim,
                            input int nk, input int poke, output int cyc);
        nack_n = nk; polls = 0; starts = 0; stops = 0; mismatch = 1'b0;
        @(negedge clk);
        dev = d; rw = r; max_tries = TRY_W'(lim); go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        cyc = 0;
        while (busy) begin
            cyc++;
            if (poke > 0 && cyc == poke) begin
                go = 1'b1; dev = ~d; rw = ~r; max_tries = TRY_W'(1);
            end else begin
                go = 1'b0;
            end
            @(negedge clk);
        end
        go = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 timeout", int'(timeout), 0);
        chk("R1 tries", int'(tries), 0);
    endtask

    task automatic t_first_ack;
        int cyc;
        run_poll(7'h50, 1'b0, 4, 0, 0, cyc);
        chk("R2 write byte", int'(first_byte), 8'hA0);
        chk("R4 done", int'(done), 1);
        chk("R4 tries", int'(tries), 1);
        chk("R4 no stop", stops, 0);
        chk("R4 scl parked low", int'(scl_bus), 0);
        chk("R4 sda released", int'(sda_bus), 1);
        chk("R7 busy cycles", cyc, 10 * STEP);
        chk("R9 no timeout", int'(timeout), 0);
    endtask

    task automatic t_busy_then_ack;
        int cyc;
        run_poll(7'h57, 1'b1, 8, 3, 0, cyc);
        chk("R2 read byte", int'(first_byte), 8'hAF);
        chk("R3 same byte each try", int'(mismatch), 0);
        chk("R3 stops", stops, 3);
        chk("R3 starts", starts, 4);
        chk("R4 tries", int'(tries), 4);
        chk("R4 done", int'(done), 1);
        chk("R7 busy cycles", cyc, 43 * STEP);
        // R9: flags hold while idle
        repeat (20) @(negedge clk);
        chk("R9 done held", int'(done), 1);
        chk("R9 tries held", int'(tries), 4);
    endtask

    task automatic t_timeout;
        int cyc;
        run_poll(7'h2C, 1'b0, 5, 1000, 0, cyc);
        chk("R5 timeout", int'(timeout), 1);
        chk("R5 done low", int'(done), 0);
        chk("R5 tries", int'(tries), 5);
        chk("R5 stops", stops, 5);
        chk("R5 scl released", int'(scl_bus), 1);
        chk("R5 sda released", int'(sda_bus), 1);
        chk("R7 busy cycles", cyc, 55 * STEP);
    endtask

    task automatic t_limit_zero;
        int cyc;
        run_poll(7'h11, 1'b1, 0, 1000, 0, cyc);
        chk("R5 zero limit timeout", int'(timeout), 1);
        chk("R5 zero limit tries", int'(tries), 1);
        chk("R7 busy cycles", cyc, 11 * STEP);
    endtask

    task automatic t_go_while_busy;
        int cyc;
        run_poll(7'h3A, 1'b0, 6, 2, 500, cyc);
        chk("R8 byte unchanged", int'(first_byte), 8'h74);
        chk("R8 all tries same", int'(mismatch), 0);
        chk("R8 tries", int'(tries), 3);
        chk("R8 done", int'(done), 1);
        chk("R8 busy cycles", cyc, 32 * STEP);
    endtask

    task automatic t_ack_on_last;
        int cyc;
        run_poll(7'h7F, 1'b1, 5, 4, 0, cyc);
        chk("R3 ack on last try done", int'(done), 1);
        chk("R3 ack on last no timeout", int'(timeout), 0);
        chk("R9 timeout cleared", int'(timeout), 0);
        chk("R3 tries", int'(tries), 5);
        chk("R2 byte", int'(first_byte), 8'hFF);
        chk("R7 busy cycles", cyc, 54 * STEP);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_first_ack();
        t_busy_then_ack();
        t_timeout();
        t_limit_zero();
        t_go_while_busy();
        t_ack_on_last();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule